// File: doc/BRIEF.md
# Pipelined AES-128 Round-Key Generator

This block expands a 128-bit AES cipher key into the eleven round keys of AES-128. Its structure is unrolled: ten registered expansion stages sit in a chain. Each stage receives the previous round key one clock after the stage before it. A round key therefore travels down the chain in step with the data block that uses it in an outer-round-pipelined cipher. Round key 0 is the cipher key itself, captured into the first register.

A `start` strobe marks a block entering the pipeline. If `key_load` is high in the same cycle, the block uses `key_in`. Otherwise it reuses the most recently loaded key. Each block carries its own key, so the key can change from one block to the next with no flush and no bubble. A valid flag travels with every round key and shows which stages hold a live block.

Top module: `aes_ks_pipe`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every bit of `rk_vld` is 0.
- R2: When `start` and `key_load` are high at a clock edge, after that edge `rk_vld[0]` is 1 and round key 0 (`rk_all[127:0]`) equals the sampled `key_in`.
- R3: When `start` is high and `key_load` is low, round key 0 equals the key from the most recent edge at which `key_load` was high, whether or not `start` was high at that edge. Before any load, this key is zero.
- R4: Round key r (`rk_all[128*r +: 128]`) and its flag `rk_vld[r]` belong to the block started r+1 clock edges earlier. Flag r is 1 exactly when that edge had `start` high.
- R5: A round key is four 32-bit words, with word 0 in bits 127:96. Round key r is built from round key r-1 as follows. Take word 3, rotate it left by one byte (the top byte moves to the bottom), and pass each byte through the AES S-box. XOR the result with the round constant, which sits in bits 31:24. Word 0 is old word 0 XOR this value. Each later word i is old word i XOR new word i-1.
- R6: The round constants for rounds 1 to 10 are 01, 02, 04, 08, 10, 20, 40, 80, 1B and 36, in hexadecimal.
- R7: For cipher key 2b7e151628aed2a6abf7158809cf4f3c, round key 1 is a0fafe1788542cb123a339392a6c7605 and round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R8: Blocks started on consecutive cycles with different keys each receive their own correct schedule at every stage.
- R9: A clock edge with `start` low puts no live block into stage 0 (`rk_vld[0]` is 0 after it).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_in | input | 128 | Cipher key |
| key_load | input | 1 | Use and store `key_in` as the current key |
| start | input | 1 | A block enters the pipeline this cycle |
| rk_vld | output | 11 | Valid flag for each round-key stage |
| rk_all | output | 1408 | Round keys 0 to 10; key r is in bits 128*r+127 down to 128*r |

## Verification
Round key 0 is due one edge after its `start`, and round key r is due r edges after that, so the key and flag of stage r belong to the cycle that lies r+1 edges back. The bench records the start strobe and the key in use for every cycle. At each falling edge it looks up, for every stage, the block issued r+1 cycles earlier and compares that stage's flag and key against its own expansion model. Directed cycles cover the reference key, back-to-back key changes, a load with no start followed by a start with no load, and idle gaps. Random traffic fills the remaining cycles.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  localparam int KEY_W    = 128;
  localparam int WORD_W   = 32;
  localparam int N_ROUNDS = 10;
  localparam int N_KEYS   = N_ROUNDS + 1;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] aa;
    p  = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xtime(aa);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // S-box value: multiplicative inverse (x^254) followed by the affine map
  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] inv;
    inv = 8'h01;
    for (int i = 0; i < 254; i++) inv = gf_mul(inv, x);
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  // Round constant for round r (1-based): doubling in GF(2^8) from 01
  function automatic logic [7:0] rcon_calc(input int r);
    logic [7:0] c;
    c = 8'h01;
    for (int i = 1; i < r; i++) c = xtime(c);
    return c;
  endfunction
endpackage

// File: rtl/aes_ks_sbox4.sv
module aes_ks_sbox4
  import aes_ks_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);
  localparam int ENTRIES = 256;

  logic [7:0] lut [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_lut
    localparam logic [7:0] VAL = sbox_calc(8'(i));
    assign lut[i] = VAL;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign dout[8*b +: 8] = lut[din[8*b +: 8]];
  end
endmodule

// File: rtl/aes_ks_step.sv
module aes_ks_step
  import aes_ks_pkg::*;
#(
  parameter logic [7:0] RCON = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_in,
  input  logic [KEY_W-1:0] rk_in,
  output logic             vld_out,
  output logic [KEY_W-1:0] rk_out
);
  localparam int WORDS = KEY_W / WORD_W;

  logic [WORD_W-1:0] w_in  [WORDS];
  logic [WORD_W-1:0] w_nxt [WORDS];
  logic [WORD_W-1:0] rot_w;
  logic [WORD_W-1:0] sub_w;
  logic [WORD_W-1:0] mix_w;
  logic [KEY_W-1:0]  rk_nxt;

  for (genvar i = 0; i < WORDS; i++) begin : g_split
    assign w_in[i] = rk_in[KEY_W-1-WORD_W*i -: WORD_W];
  end

  assign rot_w = {w_in[WORDS-1][WORD_W-9:0], w_in[WORDS-1][WORD_W-1 -: 8]};

  aes_ks_sbox4 #(.LANES(WORD_W/8)) u_sub (
    .din  (rot_w),
    .dout (sub_w)
  );

  assign mix_w    = sub_w ^ {RCON, {(WORD_W-8){1'b0}}};
  assign w_nxt[0] = w_in[0] ^ mix_w;

  for (genvar i = 1; i < WORDS; i++) begin : g_chain
    assign w_nxt[i] = w_in[i] ^ w_nxt[i-1];
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_join
    assign rk_nxt[KEY_W-1-WORD_W*i -: WORD_W] = w_nxt[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out <= 1'b0;
      rk_out  <= '0;
    end else begin
      vld_out <= vld_in;
      rk_out  <= rk_nxt;
    end
  end

  // R5: new word1 ^ new word0 equals old word1
  assert_w1_chain_R5: assert property (@(posedge clk) disable iff (rst)
    vld_out |-> ((rk_out[95:64] ^ rk_out[127:96]) == $past(rk_in[95:64])));

  // R5: new word3 ^ new word2 equals old word3
  assert_w3_chain_R5: assert property (@(posedge clk) disable iff (rst)
    vld_out |-> ((rk_out[31:0] ^ rk_out[63:32]) == $past(rk_in[31:0])));
endmodule

// File: rtl/aes_ks_pipe.sv
module aes_ks_pipe
  import aes_ks_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [KEY_W-1:0]          key_in,
  input  logic                      key_load,
  input  logic                      start,
  output logic [N_KEYS-1:0]         rk_vld,
  output logic [KEY_W*N_KEYS-1:0]   rk_all
);
  logic [KEY_W-1:0] held_q;
  logic [KEY_W-1:0] rk0_q;
  logic             vld0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      rk0_q  <= '0;
      vld0_q <= 1'b0;
    end else begin
      if (key_load) held_q <= key_in;
      if (start)    rk0_q  <= key_load ? key_in : held_q;
      vld0_q <= start;
    end
  end

  assign rk_vld[0]         = vld0_q;
  assign rk_all[KEY_W-1:0] = rk0_q;

  for (genvar r = 1; r <= N_ROUNDS; r++) begin : g_round
    aes_ks_step #(.RCON(rcon_calc(r))) u_step (
      .clk     (clk),
      .rst     (rst),
      .vld_in  (rk_vld[r-1]),
      .rk_in   (rk_all[KEY_W*(r-1) +: KEY_W]),
      .vld_out (rk_vld[r]),
      .rk_out  (rk_all[KEY_W*r +: KEY_W])
    );

    // R4: a live stage r must have been fed by a live stage r-1
    assert_vld_track_R4: assert property (@(posedge clk) disable iff (rst)
      rk_vld[r] |-> $past(rk_vld[r-1]));
  end

  // R2: start with load captures the presented key into stage 0
  assert_load_key_R2: assert property (@(posedge clk) disable iff (rst)
    (start && key_load) |=> (rk_vld[0] && rk_all[KEY_W-1:0] == $past(key_in)));

  // R3: start without load reuses the stored key
  assert_reuse_key_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !key_load) |=> (rk_all[KEY_W-1:0] == $past(held_q)));

  // R9: no start, no live block in stage 0
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !start |=> !rk_vld[0]);
endmodule

// File: tb/aes_ks_pipe_tb.sv
module aes_ks_pipe_tb;
  localparam int NC = 400;
  localparam logic [127:0] FIPS_KEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] FIPS_RK1 = 128'ha0fafe1788542cb123a339392a6c7605;
  localparam logic [127:0] FIPS_RK10 = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [127:0]    key_in = '0;
  logic            key_load = 1'b0;
  logic            start = 1'b0;
  logic [10:0]     rk_vld;
  logic [1407:0]   rk_all;

  int n_tests = 0;
  int n_fail  = 0;

  logic         iss   [NC];
  logic         ldd   [NC];
  logic [127:0] kused [NC];
  logic [127:0] held  = '0;

  always #2 clk = ~clk;

  aes_ks_pipe u_dut (
    .clk(clk), .rst(rst), .key_in(key_in), .key_load(key_load),
    .start(start), .rk_vld(rk_vld), .rk_all(rk_all)
  );

  function automatic logic [7:0] m_xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) acc ^= x;
      x = m_xt(x);
      y = y >> 1;
    end
    return acc;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] a);
    logic [7:0] inv = 0;
    logic [7:0] s;
    if (a != 0)
      for (int b = 1; b < 256; b++)
        if (m_mul(a, 8'(b)) == 8'h01) inv = 8'(b);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return s ^ 8'h63;
  endfunction

  // R6: constants listed directly
  function automatic logic [7:0] m_rcon(input int r);
    case (r)
      1: return 8'h01; 2: return 8'h02; 3: return 8'h04; 4: return 8'h08;
      5: return 8'h10; 6: return 8'h20; 7: return 8'h40; 8: return 8'h80;
      9: return 8'h1b; default: return 8'h36;
    endcase
  endfunction

  // R5: word-by-word expansion model
  function automatic logic [127:0] m_rk(input logic [127:0] key, input int r);
    logic [31:0] w [44];
    logic [31:0] t;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0]), m_sbox(t[31:24])};
        t[31:24] = t[31:24] ^ m_rcon(i/4);
      end
      w[i] = w[i-4] ^ t;
    end
    return {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endfunction

  task automatic chk_key(input string req, input int r, input logic [127:0] act,
                         input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s stage %0d key act=%h exp=%h", req, r, act, exp);
    end
  endtask

  task automatic check_cycle(input int m);
    for (int r = 0; r <= 10; r++) begin
      int n;
      logic ev;
      string req;
      n  = m - 1 - r;
      ev = (n >= 0 && n < NC) ? iss[n] : 1'b0;
      n_tests++;
      if (rk_vld[r] !== ev) begin
        n_fail++;
        $display("FAIL R4 stage %0d valid act=%b exp=%b", r, rk_vld[r], ev);
      end
      if (ev) begin
        if (n == 6 || n == 7) req = "R8";
        else if (r == 0) req = ldd[n] ? "R2" : "R3";
        else req = "R5";
        chk_key(req, r, rk_all[128*r +: 128], m_rk(kused[n], r));
        if (kused[n] == FIPS_KEY && r == 1)
          chk_key("R7", r, rk_all[128*r +: 128], FIPS_RK1);
        if (kused[n] == FIPS_KEY && r == 10)
          chk_key("R7", r, rk_all[128*r +: 128], FIPS_RK10);
      end
    end
  endtask

  task automatic drive_cycle(input int m);
    logic st, ld;
    logic [127:0] k;
    k  = {$urandom(), $urandom(), $urandom(), $urandom()};
    st = 1'b0;
    ld = 1'b0;
    if (m == 5)       begin st = 1; ld = 1; k = FIPS_KEY; end
    else if (m == 6)  begin st = 1; ld = 1; k = ~FIPS_KEY ^ 128'h1; end
    else if (m == 7)  begin st = 1; ld = 0; end
    else if (m == 25) begin st = 0; ld = 1; end
    else if (m == 27) begin st = 1; ld = 0; end   // R3: uses key from m=25
    else if (m >= 30 && m < NC - 12) begin
      st = ($urandom() % 10) < 7;
      ld = ($urandom() % 2) == 1;
    end
    iss[m]   = st;
    ldd[m]   = ld;
    kused[m] = ld ? k : held;
    if (ld) held = k;
    start    = st;
    key_load = ld;
    key_in   = k;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    n_tests++;
    if (rk_vld !== '0) begin
      n_fail++;
      $display("FAIL R1 valid during reset act=%b exp=0", rk_vld);
    end
    rst = 1'b0;
    for (int m = 0; m < NC; m++) begin
      check_cycle(m);   // R1 at m=0: nothing issued, all flags low
      drive_cycle(m);
      @(negedge clk);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule